// File: doc/BRIEF.md
# Two-Way Cache Tag Directory with Traffic Statistics

This block tracks which memory blocks a two-way set-associative, write-allocate cache would hold while a stream of 32-bit load and store references passes through it. It keeps no data. It keeps only one tag per way, one replacement bit per set and one dirty bit per line. For each reference it reports whether the reference would have hit. It also accumulates four statistics: the number of references, the number of misses, and the bytes that would cross the memory boundary under a write-back policy and under a write-through policy. Both policies are tallied at the same time, because write-allocate gives them the same miss sequence.

A reference is offered by raising `reqValid` together with an address and a store flag. The block accepts one reference per clock. The result appears on `hit` or `miss` in the following cycle, and the counters step at the same edge. Block size and capacity are set at compile time as base-2 logarithms. An illegal combination, meaning fewer than one set or an empty tag field, stops elaboration.

Top module: `cache_tag_dir`

## Requirements
- R1: The address splits into three fields, from least significant to most significant. The offset is the low LOG2_BLOCK bits. The set index is the next LOG2_CAP-LOG2_BLOCK-1 bits. The tag is all remaining bits up to bit 31. The offset bits never affect the outcome.
- R2: A synchronous active-high reset zeroes every tag, every replacement bit (so way 0 is replaced first) and every dirty bit, along with all four counters, `hit` and `miss`. There are no valid bits: a zero tag counts as resident from reset on.
- R3: A reference hits when its tag equals the tag of either way in its set, and loads and stores are judged alike. When both ways match, way 0 is the way accessed.
- R4: One cycle after an accepted reference, exactly one of `hit` and `miss` is high. Both are low in a cycle that follows no accepted reference.
- R5: On a miss, the way named by the set's replacement bit receives the new tag, and the replacement bit then names the other way.
- R6: On a hit, the set's replacement bit is set to name the way that was not accessed.
- R7: Each line has a single dirty bit. A store sets the dirty bit of the way it hits or fills. A load fill clears the dirty bit. A load hit leaves the dirty bit unchanged.
- R8: `accessCount` rises by one for each accepted reference, and `missCount` rises by one for each miss.
- R9: `wbBytes` rises by the block size on every miss (the fill), and by a further block size when the replaced line was dirty.
- R10: `wtBytes` rises by the block size on every miss, and by 4 for every store, whether the store hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | A reference is offered this cycle |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address of the reference |
| hit | output | 1 | Previous-cycle reference hit |
| miss | output | 1 | Previous-cycle reference missed |
| accessCount | output | 64 | References accepted |
| missCount | output | 64 | Misses |
| wbBytes | output | 64 | Fill bytes plus dirty-eviction bytes |
| wtBytes | output | 64 | Fill bytes plus 4 bytes per store |

## Verification
Two things can fall on one reference: a dirty eviction from the replaced way, and a store that marks the newly filled line dirty while it also adds write-through bytes. The bench provokes this with a directed store-then-evict sequence inside one set, followed by long back-to-back runs of random references over a small pool of tags, so that evictions, store fills and store hits land on consecutive cycles in both sets. An arithmetic model in the bench predicts the result and every counter for each cycle, and each one is compared one clock later.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

  localparam int unsigned STORE_BYTES = 4;

  typedef struct packed {
    logic access;      // reference accepted this cycle
    logic hit;         // tag found in the set
    logic way;         // way touched (hit way or victim)
    logic fill;        // victim receives new tag
    logic setDirty;    // reference is a store
    logic dirtyEvict;  // victim held a dirty line
  } dirCtrl_t;

endpackage

// File: rtl/cache_dir_ctrl.sv
module cache_dir_ctrl
  import cache_dir_pkg::*;
(
  input  logic       reqValid,
  input  logic       reqIsStore,
  input  logic [1:0] wayMatch,
  input  logic       victimWay,
  input  logic       victimDirty,
  output dirCtrl_t   ctrl
);

  logic anyMatch;

  always_comb begin
    anyMatch        = |wayMatch;
    ctrl.access     = reqValid;
    ctrl.hit        = reqValid && anyMatch;
    ctrl.way        = anyMatch ? !wayMatch[0] : victimWay;
    ctrl.fill       = reqValid && !anyMatch;
    ctrl.setDirty   = reqValid && reqIsStore;
    ctrl.dirtyEvict = reqValid && !anyMatch && victimDirty;
  end

endmodule

// File: rtl/cache_dir_datapath.sv
module cache_dir_datapath
  import cache_dir_pkg::*;
#(
  parameter int LOG2_BLOCK = 6,
  parameter int LOG2_CAP   = 12
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] reqAddr,
  input  dirCtrl_t    ctrl,
  output logic [1:0]  wayMatch,
  output logic        victimWay,
  output logic        victimDirty
);

  localparam int IDX_W  = LOG2_CAP - LOG2_BLOCK - 1;
  localparam int IDX_WS = (IDX_W > 0) ? IDX_W : 1;
  localparam int SETS   = 1 << IDX_W;
  localparam int TAG_LO = LOG2_BLOCK + IDX_W;
  localparam int TAG_W  = 32 - TAG_LO;

  logic [TAG_W-1:0]  tagMem   [SETS][2];
  logic [1:0]        dirtyMem [SETS];
  logic [SETS-1:0]   lruMem;
  logic [IDX_WS-1:0] setIdx;
  logic [TAG_W-1:0]  reqTag;

  assign reqTag = reqAddr[31:TAG_LO];

  generate
    if (IDX_W > 0) begin : gIdx
      assign setIdx = reqAddr[LOG2_BLOCK +: IDX_WS];
    end else begin : gNoIdx
      assign setIdx = '0;
    end
    for (genvar w = 0; w < 2; w++) begin : gWay
      assign wayMatch[w] = (tagMem[setIdx][w] == reqTag);
    end
  endgenerate

  assign victimWay   = lruMem[setIdx];
  assign victimDirty = dirtyMem[setIdx][victimWay];

  always_ff @(posedge clk) begin
    if (rst) begin
      lruMem <= '0;
      for (int s = 0; s < SETS; s++) begin
        tagMem[s][0] <= '0;
        tagMem[s][1] <= '0;
        dirtyMem[s]  <= '0;
      end
    end else if (ctrl.access) begin
      lruMem[setIdx] <= !ctrl.way;
      if (ctrl.fill) begin
        tagMem[setIdx][ctrl.way]   <= reqTag;
        dirtyMem[setIdx][ctrl.way] <= ctrl.setDirty;
      end else if (ctrl.setDirty) begin
        dirtyMem[setIdx][ctrl.way] <= 1'b1;
      end
    end
  end

  assert_fill_tag_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.fill |=> tagMem[$past(setIdx)][$past(ctrl.way)] == $past(reqTag));

  assert_lru_other_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.access |=> lruMem[$past(setIdx)] != $past(ctrl.way));

  assert_store_dirty_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.setDirty |=> dirtyMem[$past(setIdx)][$past(ctrl.way)]);

endmodule

// File: rtl/cache_dir_stats.sv
module cache_dir_stats
  import cache_dir_pkg::*;
#(
  parameter int LOG2_BLOCK = 6
)(
  input  logic        clk,
  input  logic        rst,
  input  dirCtrl_t    ctrl,
  output logic        hit,
  output logic        miss,
  output logic [63:0] accessCount,
  output logic [63:0] missCount,
  output logic [63:0] wbBytes,
  output logic [63:0] wtBytes
);

  localparam logic [63:0] BLK = 64'd1 << LOG2_BLOCK;
  localparam logic [63:0] STB = 64'(STORE_BYTES);

  logic [63:0] fillAdd, wbAdd, wtAdd;

  always_comb begin
    fillAdd = ctrl.fill ? BLK : 64'd0;
    wbAdd   = fillAdd + (ctrl.dirtyEvict ? BLK : 64'd0);
    wtAdd   = fillAdd + (ctrl.setDirty ? STB : 64'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit         <= 1'b0;
      miss        <= 1'b0;
      accessCount <= '0;
      missCount   <= '0;
      wbBytes     <= '0;
      wtBytes     <= '0;
    end else begin
      hit         <= ctrl.hit;
      miss        <= ctrl.fill;
      accessCount <= accessCount + {63'd0, ctrl.access};
      missCount   <= missCount + {63'd0, ctrl.fill};
      wbBytes     <= wbBytes + wbAdd;
      wtBytes     <= wtBytes + wtAdd;
    end
  end

  assert_one_result_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.access |=> (hit != miss));

  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.access |=> (!hit && !miss && accessCount == $past(accessCount)));

  assert_miss_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (missCount == $past(missCount) || missCount == $past(missCount) + 64'd1));

  assert_wb_step_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wbBytes == $past(wbBytes) || wbBytes == $past(wbBytes) + BLK
              || wbBytes == $past(wbBytes) + 2 * BLK));

  assert_wt_step_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wtBytes == $past(wtBytes) || wtBytes == $past(wtBytes) + STB
              || wtBytes == $past(wtBytes) + BLK || wtBytes == $past(wtBytes) + BLK + STB));

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import cache_dir_pkg::*;
#(
  parameter int LOG2_BLOCK = 6,
  parameter int LOG2_CAP   = 12
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqIsStore,
  input  logic [31:0] reqAddr,
  output logic        hit,
  output logic        miss,
  output logic [63:0] accessCount,
  output logic [63:0] missCount,
  output logic [63:0] wbBytes,
  output logic [63:0] wtBytes
);

  localparam int IDX_W = LOG2_CAP - LOG2_BLOCK - 1;
  localparam int TAG_W = 32 - LOG2_BLOCK - IDX_W;

  generate
    if (IDX_W < 0 || TAG_W < 1 || LOG2_BLOCK < 0) begin : gBadCfg
      $error("cache_tag_dir: need at least one set and a non-empty tag");
    end
  endgenerate

  dirCtrl_t   ctrl;
  logic [1:0] wayMatch;
  logic       victimWay, victimDirty;

  cache_dir_datapath #(.LOG2_BLOCK(LOG2_BLOCK), .LOG2_CAP(LOG2_CAP)) u_dp (
    .clk(clk), .rst(rst), .reqAddr(reqAddr), .ctrl(ctrl),
    .wayMatch(wayMatch), .victimWay(victimWay), .victimDirty(victimDirty)
  );

  cache_dir_ctrl u_ctrl (
    .reqValid(reqValid), .reqIsStore(reqIsStore), .wayMatch(wayMatch),
    .victimWay(victimWay), .victimDirty(victimDirty), .ctrl(ctrl)
  );

  cache_dir_stats #(.LOG2_BLOCK(LOG2_BLOCK)) u_stats (
    .clk(clk), .rst(rst), .ctrl(ctrl), .hit(hit), .miss(miss),
    .accessCount(accessCount), .missCount(missCount),
    .wbBytes(wbBytes), .wtBytes(wtBytes)
  );

endmodule

// File: tb/cache_tag_dir_bench.sv
module cache_tag_dir_bench;

  localparam int LB     = 3;            // 8-byte blocks
  localparam int LC     = 5;            // 32-byte capacity -> 2 sets
  localparam int IDXW   = LC - LB - 1;
  localparam int NSETS  = 1 << IDXW;
  localparam int TAGLO  = LB + IDXW;
  localparam longint BS = 64'd1 << LB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqIsStore = 1'b0;
  logic [31:0] reqAddr = '0;
  logic hit, miss;
  logic [63:0] accessCount, missCount, wbBytes, wtBytes;

  always #10 clk = ~clk;   // 50 MHz

  cache_tag_dir #(.LOG2_BLOCK(LB), .LOG2_CAP(LC)) u_cache_tag_dir (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqAddr(reqAddr), .hit(hit), .miss(miss), .accessCount(accessCount),
    .missCount(missCount), .wbBytes(wbBytes), .wtBytes(wtBytes)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] refTag   [NSETS][2];
  bit          refDirty [NSETS][2];
  bit          refLru   [NSETS];
  bit          expHit, expMiss;
  longint      expAcc, expMis, expWb, expWt;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tg, input int idx, input int off);
    return (32'(tg) << TAGLO) | (32'(idx) << LB) | 32'(off);
  endfunction

  task automatic modelStep(input bit st, input logic [31:0] a);
    int idx, way;
    logic [31:0] tg;
    tg  = a >> TAGLO;
    idx = int'((a >> LB) % NSETS);
    expAcc++;
    if (refTag[idx][0] == tg) begin way = 0; expHit = 1; end
    else if (refTag[idx][1] == tg) begin way = 1; expHit = 1; end
    else begin way = int'(refLru[idx]); expHit = 0; end
    expMiss = !expHit;
    if (expMiss) begin
      expMis++; expWb += BS; expWt += BS;
      if (refDirty[idx][way]) expWb += BS;
      refTag[idx][way] = tg;
      refDirty[idx][way] = st;
    end else if (st) refDirty[idx][way] = 1;
    if (st) expWt += 4;
    refLru[idx] = (way == 0);
  endtask

  // one clock: check the result of the previous cycle, then drive this one
  task automatic cyc(input bit v, input bit st, input logic [31:0] a);
    @(negedge clk);
    chk(hit == expHit && miss == expMiss, "R1 R3 R4 R5 R6 hit/miss",
        longint'({hit, miss}), longint'({expHit, expMiss}));
    chk(accessCount == expAcc && missCount == expMis, "R8 counts",
        longint'(missCount), expMis);
    chk(wbBytes == expWb, "R7 R9 write-back bytes", longint'(wbBytes), expWb);
    chk(wtBytes == expWt, "R10 write-through bytes", longint'(wtBytes), expWt);
    reqValid = v; reqIsStore = st; reqAddr = a;
    if (v) modelStep(st, a);
    else begin expHit = 0; expMiss = 0; end
  endtask

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      refTag[s][0] = 0; refTag[s][1] = 0;
      refDirty[s][0] = 0; refDirty[s][1] = 0; refLru[s] = 0;
    end
    expHit = 0; expMiss = 0; expAcc = 0; expMis = 0; expWb = 0; expWt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state visible after reset
    @(negedge clk);
    chk(!hit && !miss && accessCount == 0 && missCount == 0 && wbBytes == 0 && wtBytes == 0,
        "R2 reset state", longint'(wbBytes), 0);
    // Directed: set 0
    cyc(1, 0, mk(0, 0, 5));   // R2 zero tag resident, both ways match -> way0 hit
    cyc(1, 1, mk(1, 0, 1));   // store miss fills way1, dirty
    cyc(1, 0, mk(2, 0, 0));   // load miss fills way0 (clean zero-tag line)
    cyc(1, 0, mk(3, 0, 2));   // evicts dirty tag1 -> extra write-back
    cyc(1, 1, mk(3, 0, 7));   // R1 other offset, store hit
    cyc(0, 0, 0);             // idle: R4 quiet
    cyc(1, 0, mk(3, 1, 0));   // R1 same tag other set: miss
    cyc(1, 1, mk(32'h0FFF_FFF, 1, 3)); // high tag bits
    cyc(1, 0, mk(32'h0FFF_FFF, 1, 0)); // hit
    cyc(1, 0, mk(3, 0, 4));   // hit back-to-back
    // random sweep, mostly back-to-back
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 15) cyc(0, 0, 0);
      else cyc(1, $urandom_range(0, 2) == 0,
               mk(int'($urandom_range(0, 4)), int'($urandom_range(0, NSETS - 1)),
                  int'($urandom_range(0, int'(BS) - 1))));
    end
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule